// File: doc/BRIEF.md
# Pipelined Correlator Lag Cell

This block is a single lag of a digital cross-correlator. Each clock it captures one sample from a prompt stream and one from a delayed stream, both coded as two-bit sign/magnitude values standing for -3, -1, +1 or +3. It turns the pair into a small unsigned score and integrates that score over long runs. Many such cells are chained: the prompt sample leaves the cell one cycle after it arrived and the delayed sample leaves two cycles after, so each further cell sees the delayed stream shifted by one more sample.

The score is an offset, rounded product kept in three bits (0 to 6), so all later arithmetic is unsigned. The score goes into a three-bit running sum that is split into one register stage per bit, with operands skewed so no carry ripples through more than one bit in a cycle. Only the carry out of the top bit reaches a wide saturating counter, so the count is the score total divided by eight. An array controller clears the integration or freezes it between readouts.

Top module: `corr_lag_cell`

## Requirements
- R1: With codes 11=-3, 10=-1, 00=+1, 01=+3 (bit 1 is the sign, bit 0 selects magnitude 3), the score of a pair is (p*d+9)/3, except that a pair in which both magnitudes are 1 scores 3.
- R2: With clear and freeze low, after the pipeline has drained, `count` equals the sum of all integrated scores divided by 8 (rounded down), and it never decreases except on clear.
- R3: `promptOut` equals the `promptIn` value sampled at the previous clock edge.
- R4: `delayOut` equals the `delayIn` value sampled two clock edges earlier.
- R5: A clock edge with `clear` high sets `count` to 0 and drops the running sum and every sample in flight, including the one held in the input register; clear has priority over freeze.
- R6: A clock edge with `freeze` high (clear low) leaves `count` and the whole accumulation pipeline unchanged; the sample held in the input register at that edge is not integrated, and samples already inside the pipeline resume when freeze falls.
- R7: `count` saturates at all ones and stays there until cleared.
- R8: After reset `count`, `promptOut` and `delayOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart integration from zero |
| freeze | input | 1 | Hold the integration state |
| promptIn | input | 2 | Prompt sample code |
| delayIn | input | 2 | Delayed sample code |
| promptOut | output | 2 | Prompt sample to the next lag |
| delayOut | output | 2 | Delayed sample to the next lag, one extra cycle behind |
| count | output | CNT_W | Integrated value (score total / 8) |

## Verification
The product rule is swept over all sixteen code pairs, each held constant for sixteen samples so that the count, twice the score, pins every table entry apart, including the rounded centre and the sign-mismatch corners. A cycling mix of pairs checks that the bit-skewed carry pipeline adds different scores in consecutive cycles correctly, which a constant stream would not reveal. Freeze windows and a mid-run clear show which samples are kept and which are dropped at the input register, and a long run of score 6 with a narrow counter drives saturation. A walking pattern on both inputs separates the one-cycle and two-cycle pass-through paths.

// File: rtl/corr_lag_pkg.sv
package corr_lag_pkg;

  localparam int PROD_W = 3;

  typedef struct packed {
    logic clr;
    logic adv;
  } lagStrobe_t;

  // Offset, rounded product of two sign/magnitude codes.
  // Bit 1 of a code is the sign, bit 0 selects magnitude 3 over 1.
  function automatic logic [PROD_W-1:0] lagProduct(input logic [1:0] p, input logic [1:0] d);
    logic sameSign;
    sameSign = (p[1] == d[1]);
    if (!p[0] && !d[0]) begin
      lagProduct = 3'd3;
    end else if (p[0] && d[0]) begin
      lagProduct = sameSign ? 3'd6 : 3'd0;
    end else begin
      lagProduct = sameSign ? 3'd4 : 3'd2;
    end
  endfunction

endpackage

// File: rtl/corr_lag_ctrl.sv
module corr_lag_ctrl
  import corr_lag_pkg::*;
(
  input  logic       clear,
  input  logic       freeze,
  output lagStrobe_t strobe
);

  always_comb begin
    strobe.clr = clear;
    strobe.adv = !clear && !freeze;
  end

endmodule

// File: rtl/corr_lag_datapath.sv
module corr_lag_datapath
  import corr_lag_pkg::*;
#(
  parameter int CNT_W = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  lagStrobe_t       strobe,
  input  logic [1:0]       promptIn,
  input  logic [1:0]       delayIn,
  output logic [1:0]       promptOut,
  output logic [1:0]       delayOut,
  output logic [CNT_W-1:0] count
);

  localparam int ACC_W = PROD_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] promptQ;
  logic [1:0] delayQ;
  logic [1:0] delayQ2;
  logic [ACC_W-1:0] prodNow;
  logic [CNT_W-1:0] countQ;
  logic topCarry;

  // Sample capture and pass-through; these follow the streams regardless of clear or freeze.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      promptQ <= '0;
      delayQ  <= '0;
      delayQ2 <= '0;
    end else begin
      promptQ <= promptIn;
      delayQ  <= delayIn;
      delayQ2 <= delayQ;
    end
  end

  always_comb prodNow = lagProduct(promptQ, delayQ);

  // One register stage per accumulator bit; operand bit k waits k cycles.
  for (genvar k = 0; k < ACC_W; k++) begin : g_bit
    logic accQ;
    logic carryQ;
    logic opBit;
    logic carryIn;

    if (k == 0) begin : g_first
      always_comb begin
        opBit   = prodNow[0];
        carryIn = 1'b0;
      end
    end else begin : g_later
      logic [ACC_W-1:k] opQ;
      if (k == 1) begin : g_src
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)             opQ <= '0;
          else if (strobe.clr)   opQ <= '0;
          else if (strobe.adv)   opQ <= prodNow[ACC_W-1:1];
        end
      end else begin : g_src
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)             opQ <= '0;
          else if (strobe.clr)   opQ <= '0;
          else if (strobe.adv)   opQ <= g_bit[k-1].g_later.opQ[ACC_W-1:k];
        end
      end
      always_comb begin
        opBit   = opQ[k];
        carryIn = g_bit[k-1].carryQ;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accQ   <= 1'b0;
        carryQ <= 1'b0;
      end else if (strobe.clr) begin
        accQ   <= 1'b0;
        carryQ <= 1'b0;
      end else if (strobe.adv) begin
        accQ   <= accQ ^ opBit ^ carryIn;
        carryQ <= (accQ & opBit) | (accQ & carryIn) | (opBit & carryIn);
      end
    end
  end

  always_comb topCarry = g_bit[ACC_W-1].carryQ;

  // Wide integration counter, advanced only by carries out of the top bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.clr) begin
      countQ <= '0;
    end else if (strobe.adv && topCarry && (countQ != CNT_MAX)) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign promptOut = promptQ;
  assign delayOut  = delayQ2;
  assign count     = countQ;

endmodule

// File: rtl/corr_lag_cell.sv
module corr_lag_cell
  import corr_lag_pkg::*;
#(
  parameter int CNT_W = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             freeze,
  input  logic [1:0]       promptIn,
  input  logic [1:0]       delayIn,
  output logic [1:0]       promptOut,
  output logic [1:0]       delayOut,
  output logic [CNT_W-1:0] count
);

  lagStrobe_t strobe;

  corr_lag_ctrl uCtrl (
    .clear  (clear),
    .freeze (freeze),
    .strobe (strobe)
  );

  corr_lag_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .promptIn  (promptIn),
    .delayIn   (delayIn),
    .promptOut (promptOut),
    .delayOut  (delayOut),
    .count     (count)
  );

endmodule

// File: rtl/corr_lag_cell_chk.sv
module corr_lag_cell_chk #(
  parameter int CNT_W = 36
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             freeze,
  input logic [1:0]       promptIn,
  input logic [1:0]       delayIn,
  input logic [1:0]       promptOut,
  input logic [1:0]       delayOut,
  input logic [CNT_W-1:0] count
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !clear) |=> (count == $past(count)));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((&count) && !clear) |=> (&count));

  // R2
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (count >= $past(count)));

  // R3
  prompt_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0) |-> (promptOut == $past(promptIn)));

  // R4
  delay_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2) |-> (delayOut == $past(delayIn, 2)));

endmodule

bind corr_lag_cell corr_lag_cell_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/corr_lag_cell_test.sv
module corr_lag_cell_test;

  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic freeze = 1'b0;
  logic [1:0] promptIn = 2'b00;
  logic [1:0] delayIn = 2'b00;
  logic [1:0] promptOut;
  logic [1:0] delayOut;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  int modelSum = 0;
  logic [1:0] lastP = 2'b00;
  logic [1:0] lastD = 2'b00;
  bit done = 0;

  corr_lag_cell #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .freeze(freeze),
    .promptIn(promptIn), .delayIn(delayIn),
    .promptOut(promptOut), .delayOut(delayOut), .count(count)
  );

  always #10 clk = ~clk;

  function automatic int codeVal(input logic [1:0] c);
    case (c)
      2'b11:   return -3;
      2'b10:   return -1;
      2'b00:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int score(input logic [1:0] p, input logic [1:0] d);
    int a;
    int b;
    a = codeVal(p);
    b = codeVal(d);
    if (a * a == 1 && b * b == 1) return 3;
    return (a * b + 9) / 3;
  endfunction

  function automatic int expCount();
    int e;
    e = modelSum / 8;
    if (e > CMAX) e = CMAX;
    return e;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive one sample; the edge that follows integrates the previously driven sample.
  task automatic step(input logic [1:0] p, input logic [1:0] d, input bit frz, input bit clr);
    @(negedge clk);
    if (clr) modelSum = 0;
    else if (!frz) modelSum += score(lastP, lastD);
    promptIn = p;
    delayIn = d;
    freeze = frz;
    clear = clr;
    lastP = p;
    lastD = d;
  endtask

  task automatic flush();
    repeat (5) step(2'b11, 2'b01, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    check("R8 count", int'(count), 0);
    check("R8 promptOut", int'(promptOut), 0);
    check("R8 delayOut", int'(delayOut), 0);

    // R1 exhaustive sweep of code pairs
    for (int pi = 0; pi < 4; pi++) begin
      for (int di = 0; di < 4; di++) begin
        step(2'(pi), 2'(di), 1'b0, 1'b1);
        repeat (15) step(2'(pi), 2'(di), 1'b0, 1'b0);
        flush();
        check($sformatf("R1 pair %0d/%0d", pi, di), int'(count), 2 * score(2'(pi), 2'(di)));
      end
    end

    // R2 mixed stream of changing pairs
    step(2'b00, 2'b00, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) step(2'(i % 4), 2'((i * 3 + 1) % 4), 1'b0, 1'b0);
    flush();
    check("R2 mixed stream", int'(count), expCount());

    // R3 R4 pass-through timing
    begin
      logic [1:0] hp [0:15];
      logic [1:0] hd [0:15];
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (i >= 2) begin
          check("R3 promptOut", int'(promptOut), int'(hp[i-1]));
          check("R4 delayOut", int'(delayOut), int'(hd[i-2]));
        end
        hp[i] = 2'(i + (i >> 2));
        hd[i] = 2'(3 * i + 1);
        promptIn = hp[i];
        delayIn = hd[i];
      end
    end

    // R6 freeze window in the middle of a run
    step(2'b11, 2'b11, 1'b0, 1'b1);
    repeat (6) step(2'b11, 2'b11, 1'b0, 1'b0);
    step(2'b01, 2'b01, 1'b1, 1'b0);
    step(2'b01, 2'b01, 1'b1, 1'b0);
    held = int'(count);
    step(2'b01, 2'b01, 1'b1, 1'b0);
    step(2'b01, 2'b01, 1'b1, 1'b0);
    step(2'b10, 2'b11, 1'b0, 1'b0);
    check("R6 count held during freeze", int'(count), held);
    repeat (5) step(2'b10, 2'b11, 1'b0, 1'b0);
    flush();
    check("R6 total after freeze", int'(count), expCount());

    // R5 clear in the middle of a run
    step(2'b11, 2'b11, 1'b0, 1'b1);
    repeat (20) step(2'b11, 2'b11, 1'b0, 1'b0);
    step(2'b10, 2'b11, 1'b0, 1'b1);
    step(2'b10, 2'b11, 1'b0, 1'b0);
    check("R5 count zero after clear", int'(count), 0);
    repeat (7) step(2'b10, 2'b11, 1'b0, 1'b0);
    flush();
    check("R5 total after clear", int'(count), expCount());
    check("R5 total value", int'(count), 4);

    // R5 clear wins over freeze
    step(2'b11, 2'b11, 1'b1, 1'b1);
    step(2'b11, 2'b11, 1'b0, 1'b0);
    check("R5 clear over freeze", int'(count), 0);

    // R7 saturation
    step(2'b01, 2'b01, 1'b0, 1'b1);
    repeat (100) step(2'b01, 2'b01, 1'b0, 1'b0);
    flush();
    check("R7 saturated", int'(count), CMAX);
    repeat (10) step(2'b01, 2'b01, 1'b0, 1'b0);
    flush();
    check("R7 stays saturated", int'(count), expCount());

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule